// File: doc/BRIEF.md
# Register-Loaded Packet Transmit Path

This block lets software on a memory-mapped control port assemble an outgoing packet one 64-bit beat at a time. Software writes a low data word and a high data word into two holding registers. It then writes a control word whose flag bits say whether this beat opens a packet, closes it, or sits in the middle. Each accepted control write pushes the held pair, with its flags, into a transmit FIFO.

A two-input arbiter sits behind the FIFO. A software-built packet competes for the output only after its closing beat is in the FIFO. It then wins over any packet offered by a second, streaming bulk source. Once a source has the grant, it keeps it until its own end-of-packet beat has gone out, so the two streams never interleave. A packet that software marks as a non-posted request must carry a tag between 16 and 31, and only one such request may be in flight. If either rule is broken, the request is discarded whole. The in-flight state clears when the completion input pulses.

Top module: `pkt_ldr_top`

## Requirements
- R1: A write to address 0 loads the low holding word and a write to address 1 loads the high holding word. The beat pushed by the next control write leaves on `out_data` with the low word in bits [31:0] and the high word in bits [63:32].
- R2: A write to address 2 is a control write. Bit 0 is start-of-packet and bit 1 is end-of-packet. The beat is pushed with these flags, so the value 3 gives a single-beat packet, 1 opens a packet, 0 is a middle beat and 2 closes a packet. Beats leave in push order.
- R3: If a control write would push while the FIFO is full, `csr_waitreq` is high until space frees. The beat is then pushed exactly once and none is lost.
- R4: A software packet is not offered on the output until its end-of-packet beat has been pushed.
- R5: When the arbiter is idle and a complete software packet is waiting, the software path is granted even if the bulk source is also valid.
- R6: A granted source keeps the grant until its end-of-packet beat is transferred. `out_from_sw` is 1 for software beats and 0 for bulk beats.
- R7: Control bit 2 marks a start beat as a non-posted request, and control bits [15:8] carry its tag. A request whose tag is outside 16 to 31 is refused: neither that beat nor any later beat up to the packet's end-of-packet write is pushed.
- R8: An accepted non-posted request sets `np_pending`. While `np_pending` is high, any further non-posted request is refused in the same way as in R7, while other packets still pass. A one-cycle pulse on `cpl_in` clears `np_pending`.
- R9: After reset, `out_valid`, `bulk_ready`, `csr_waitreq` and `np_pending` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_write | input | 1 | Control port write strobe |
| csr_addr | input | 2 | Word address: 0 low word, 1 high word, 2 control |
| csr_wdata | input | 32 | Write data |
| csr_waitreq | output | 1 | Holds off a control write while the FIFO is full |
| bulk_valid | input | 1 | Bulk source beat valid |
| bulk_data | input | 64 | Bulk source beat data |
| bulk_sop | input | 1 | Bulk source start-of-packet |
| bulk_eop | input | 1 | Bulk source end-of-packet |
| bulk_ready | output | 1 | Bulk beat accepted this cycle |
| out_valid | output | 1 | Output beat valid |
| out_data | output | 64 | Output beat data |
| out_sop | output | 1 | Output start-of-packet |
| out_eop | output | 1 | Output end-of-packet |
| out_from_sw | output | 1 | 1 if the beat comes from the software path |
| out_ready | input | 1 | Downstream accepts the beat |
| cpl_in | input | 1 | Completion received for the pending non-posted request |
| np_pending | output | 1 | A non-posted request is in flight |

## Verification
Some rules are checked by assertions on every cycle. The FIFO is never written while full. The grant never changes in the middle of a packet. The idle arbiter never hands the grant to software while no complete software packet is stored. A pushed non-posted start beat always carries an in-range tag. `np_pending` only rises on an accepted request, and no request gets through while it is high. Other behaviour shows only in the bench's directed scenarios: the word placement inside the beat, the held-off write that completes once space frees, strict priority when both sources wait at the same idle cycle, and the whole-packet drop after a refused request.

// File: rtl/pkt_ldr_pkg.sv
package pkt_ldr_pkg;

  typedef enum logic [1:0] {
    GNT_IDLE = 2'd0,
    GNT_SW   = 2'd1,
    GNT_BULK = 2'd2
  } gnt_t;

  localparam logic [1:0] ADDR_LO   = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  localparam int CTL_SOP     = 0;
  localparam int CTL_EOP     = 1;
  localparam int CTL_NP      = 2;
  localparam int CTL_TAG_LSB = 8;

endpackage

// File: rtl/pkt_ldr_regs.sv
module pkt_ldr_regs
  import pkt_ldr_pkg::*;
#(
  parameter int DW     = 32,
  parameter int TAGW   = 8,
  parameter int TAG_LO = 16,
  parameter int TAG_HI = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_write,
  input  logic [1:0]      csr_addr,
  input  logic [DW-1:0]   csr_wdata,
  output logic            csr_waitreq,
  input  logic            fifo_full,
  output logic            push,
  output logic [2*DW-1:0] push_data,
  output logic            push_sop,
  output logic            push_eop,
  input  logic            cpl_in,
  output logic            np_pending
);

  logic [DW-1:0]   lo_q, hi_q;
  logic            drop_q;
  logic            np_q;
  logic            ctrl_hit;
  logic            c_sop, c_eop, c_np;
  logic [TAGW-1:0] c_tag;
  logic            tag_ok;
  logic            refuse;
  logic            want_push;

  assign ctrl_hit  = csr_write && (csr_addr == ADDR_CTRL);
  assign c_sop     = csr_wdata[CTL_SOP];
  assign c_eop     = csr_wdata[CTL_EOP];
  assign c_np      = csr_wdata[CTL_NP];
  assign c_tag     = csr_wdata[CTL_TAG_LSB +: TAGW];
  assign tag_ok    = (c_tag >= TAGW'(TAG_LO)) && (c_tag <= TAGW'(TAG_HI));
  assign refuse    = c_sop && c_np && (np_q || !tag_ok);
  assign want_push = ctrl_hit && (c_sop ? !refuse : !drop_q);

  assign csr_waitreq = want_push && fifo_full;
  assign push        = want_push && !fifo_full;
  assign push_data   = {hi_q, lo_q};
  assign push_sop    = c_sop;
  assign push_eop    = c_eop;
  assign np_pending  = np_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      hi_q   <= '0;
      drop_q <= 1'b0;
      np_q   <= 1'b0;
    end else begin
      if (csr_write && (csr_addr == ADDR_LO)) lo_q <= csr_wdata;
      if (csr_write && (csr_addr == ADDR_HI)) hi_q <= csr_wdata;
      if (ctrl_hit) begin
        if (c_sop)      drop_q <= refuse && !c_eop;
        else if (c_eop) drop_q <= 1'b0;
      end
      if (push && c_sop && c_np) np_q <= 1'b1;
      else if (cpl_in)           np_q <= 1'b0;
    end
  end

  // R7
  np_tag_range_chk: assert property (@(posedge clk) disable iff (rst)
    (push && push_sop && csr_wdata[CTL_NP]) |->
      (c_tag >= TAGW'(TAG_LO) && c_tag <= TAGW'(TAG_HI)));

  // R8
  np_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(np_pending) |-> $past(push && push_sop && csr_wdata[CTL_NP]));

  // R8
  np_single_chk: assert property (@(posedge clk) disable iff (rst)
    (np_pending && push && push_sop) |-> !csr_wdata[CTL_NP]);

endmodule

// File: rtl/pkt_ldr_fifo.sv
module pkt_ldr_fifo #(
  parameter int W     = 66,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         pkt_avail
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic [CW-1:0] pkts;
  logic          do_push, do_pop;
  logic          in_last, out_last;

  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign dout      = mem[rptr];
  assign in_last   = din[W-1];
  assign out_last  = dout[W-1];
  assign pkt_avail = (pkts != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      pkts <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      case ({do_push && in_last, do_pop && out_last})
        2'b10:   pkts <= pkts + 1'b1;
        2'b01:   pkts <= pkts - 1'b1;
        default: pkts <= pkts;
      endcase
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && full));

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty));

  // R4
  pkt_count_chk: assert property (@(posedge clk) disable iff (rst)
    pkts <= cnt);

endmodule

// File: rtl/pkt_ldr_arb.sv
module pkt_ldr_arb
  import pkt_ldr_pkg::*;
#(
  parameter int BW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sw_valid,
  input  logic          sw_pkt_ready,
  input  logic [BW-1:0] sw_data,
  input  logic          sw_sop,
  input  logic          sw_eop,
  output logic          sw_pop,
  input  logic          bulk_valid,
  input  logic [BW-1:0] bulk_data,
  input  logic          bulk_sop,
  input  logic          bulk_eop,
  output logic          bulk_ready,
  output logic          out_valid,
  output logic [BW-1:0] out_data,
  output logic          out_sop,
  output logic          out_eop,
  output logic          out_from_sw,
  input  logic          out_ready
);

  gnt_t gnt_q, gnt_d;
  logic last_xfer;

  always_comb begin
    out_valid   = 1'b0;
    out_data    = '0;
    out_sop     = 1'b0;
    out_eop     = 1'b0;
    out_from_sw = 1'b0;
    case (gnt_q)
      GNT_SW: begin
        out_valid   = sw_valid;
        out_data    = sw_data;
        out_sop     = sw_sop;
        out_eop     = sw_eop;
        out_from_sw = 1'b1;
      end
      GNT_BULK: begin
        out_valid = bulk_valid;
        out_data  = bulk_data;
        out_sop   = bulk_sop;
        out_eop   = bulk_eop;
      end
      default: ;
    endcase
  end

  assign sw_pop     = (gnt_q == GNT_SW) && sw_valid && out_ready;
  assign bulk_ready = (gnt_q == GNT_BULK) && out_ready;
  assign last_xfer  = out_valid && out_ready && out_eop;

  always_comb begin
    gnt_d = gnt_q;
    case (gnt_q)
      GNT_IDLE: begin
        if (sw_pkt_ready)    gnt_d = GNT_SW;
        else if (bulk_valid) gnt_d = GNT_BULK;
      end
      GNT_SW, GNT_BULK: if (last_xfer) gnt_d = GNT_IDLE;
      default: gnt_d = GNT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) gnt_q <= GNT_IDLE;
    else     gnt_q <= gnt_d;
  end

  // R4
  sw_complete_only_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_q == GNT_IDLE && !sw_pkt_ready) |=> (gnt_q != GNT_SW));

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_q != GNT_IDLE && !last_xfer) |=> (gnt_q == $past(gnt_q)));

  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && !bulk_ready));

endmodule

// File: rtl/pkt_ldr_top.sv
module pkt_ldr_top
  import pkt_ldr_pkg::*;
#(
  parameter int DW         = 32,
  parameter int FIFO_DEPTH = 8,
  parameter int TAG_LO     = 16,
  parameter int TAG_HI     = 31
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            csr_write,
  input  logic [1:0]      csr_addr,
  input  logic [DW-1:0]   csr_wdata,
  output logic            csr_waitreq,
  input  logic            bulk_valid,
  input  logic [2*DW-1:0] bulk_data,
  input  logic            bulk_sop,
  input  logic            bulk_eop,
  output logic            bulk_ready,
  output logic            out_valid,
  output logic [2*DW-1:0] out_data,
  output logic            out_sop,
  output logic            out_eop,
  output logic            out_from_sw,
  input  logic            out_ready,
  input  logic            cpl_in,
  output logic            np_pending
);

  localparam int BW = 2 * DW;
  localparam int FW = BW + 2;

  logic          push, push_sop, push_eop;
  logic [BW-1:0] push_data;
  logic          fifo_full, fifo_empty, pkt_avail, sw_pop;
  logic [FW-1:0] fifo_dout;

  pkt_ldr_regs #(
    .DW(DW), .TAGW(8), .TAG_LO(TAG_LO), .TAG_HI(TAG_HI)
  ) u_regs (
    .clk(clk), .rst(rst),
    .csr_write(csr_write), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_waitreq(csr_waitreq), .fifo_full(fifo_full),
    .push(push), .push_data(push_data), .push_sop(push_sop), .push_eop(push_eop),
    .cpl_in(cpl_in), .np_pending(np_pending)
  );

  pkt_ldr_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .din({push_eop, push_sop, push_data}), .full(fifo_full),
    .pop(sw_pop), .dout(fifo_dout), .empty(fifo_empty), .pkt_avail(pkt_avail)
  );

  pkt_ldr_arb #(.BW(BW)) u_arb (
    .clk(clk), .rst(rst),
    .sw_valid(!fifo_empty), .sw_pkt_ready(pkt_avail),
    .sw_data(fifo_dout[BW-1:0]), .sw_sop(fifo_dout[BW]), .sw_eop(fifo_dout[BW+1]),
    .sw_pop(sw_pop),
    .bulk_valid(bulk_valid), .bulk_data(bulk_data), .bulk_sop(bulk_sop),
    .bulk_eop(bulk_eop), .bulk_ready(bulk_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_from_sw(out_from_sw), .out_ready(out_ready)
  );

  // R3
  waitreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    csr_waitreq |-> csr_write);

endmodule

// File: tb/pkt_ldr_top_test.sv
module pkt_ldr_top_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_write = 1'b0;
  logic [1:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic        csr_waitreq;
  logic        bulk_valid = 1'b0;
  logic [63:0] bulk_data = '0;
  logic        bulk_sop = 1'b0, bulk_eop = 1'b0;
  logic        bulk_ready;
  logic        out_valid, out_sop, out_eop, out_from_sw;
  logic [63:0] out_data;
  logic        out_ready = 1'b1;
  logic        cpl_in = 1'b0;
  logic        np_pending;

  int checks = 0;
  int errors = 0;

  logic [63:0] m_data [0:63];
  logic        m_sop  [0:63];
  logic        m_eop  [0:63];
  logic        m_src  [0:63];
  int          m_n = 0;

  always #10 clk = ~clk;

  pkt_ldr_top uut (
    .clk(clk), .rst(rst),
    .csr_write(csr_write), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_waitreq(csr_waitreq),
    .bulk_valid(bulk_valid), .bulk_data(bulk_data), .bulk_sop(bulk_sop),
    .bulk_eop(bulk_eop), .bulk_ready(bulk_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop),
    .out_eop(out_eop), .out_from_sw(out_from_sw), .out_ready(out_ready),
    .cpl_in(cpl_in), .np_pending(np_pending)
  );

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && m_n < 64) begin
      m_data[m_n] = out_data;
      m_sop[m_n]  = out_sop;
      m_eop[m_n]  = out_eop;
      m_src[m_n]  = out_from_sw;
      m_n = m_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_beat(input int i, input string req, input logic [63:0] d,
                          input bit s, input bit e, input bit src);
    chk(i < m_n, req, 64'(m_n), 64'(i + 1));
    if (i < m_n) begin
      chk(m_data[i] == d, req, m_data[i], d);
      chk({m_sop[i], m_eop[i], m_src[i]} == {s, e, src}, req,
          64'({m_sop[i], m_eop[i], m_src[i]}), 64'({s, e, src}));
    end
  endtask

  // called at posedge+2; returns at posedge+2 after the write is taken
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    csr_write = 1'b1; csr_addr = a; csr_wdata = d;
    do @(negedge clk); while (csr_waitreq);
    @(posedge clk); #2;
    csr_write = 1'b0;
  endtask

  task automatic sw_beat(input logic [31:0] lo, input logic [31:0] hi,
                         input logic [31:0] ctl);
    wr(2'd0, lo); wr(2'd1, hi); wr(2'd2, ctl);
  endtask

  task automatic bulk_beat(input logic [63:0] d, input bit s, input bit e);
    bulk_valid = 1'b1; bulk_data = d; bulk_sop = s; bulk_eop = e;
    do @(negedge clk); while (!bulk_ready);
    @(posedge clk); #2;
    bulk_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid, "R9 out_valid", 64'(out_valid), 0);
    chk(!bulk_ready, "R9 bulk_ready", 64'(bulk_ready), 0);
    chk(!csr_waitreq, "R9 csr_waitreq", 64'(csr_waitreq), 0);
    chk(!np_pending, "R9 np_pending", 64'(np_pending), 0);
    @(posedge clk); #2;
  endtask

  task automatic t_single;
    int b = m_n;
    sw_beat(32'hA5A5_0001, 32'h5A5A_0002, 32'h3);
    idle(8);
    chk(m_n == b + 1, "R2 single count", 64'(m_n - b), 1);
    chk_beat(b, "R1 R2 single beat", 64'h5A5A_0002_A5A5_0001, 1, 1, 1);
  endtask

  task automatic t_multi;
    int b = m_n;
    sw_beat(32'h11, 32'h12, 32'h1);
    sw_beat(32'h21, 32'h22, 32'h0);
    idle(6);
    @(negedge clk);
    chk(m_n == b && !out_valid, "R4 held until end", 64'(m_n - b), 0);
    @(posedge clk); #2;
    sw_beat(32'h31, 32'h32, 32'h2);
    idle(8);
    chk(m_n == b + 3, "R2 three beats", 64'(m_n - b), 3);
    chk_beat(b,     "R2 first",  64'h12_0000_0011, 1, 0, 1);
    chk_beat(b + 1, "R2 middle", 64'h22_0000_0021, 0, 0, 1);
    chk_beat(b + 2, "R2 last",   64'h32_0000_0031, 0, 1, 1);
  endtask

  task automatic t_priority;
    int b = m_n;
    out_ready = 1'b0;
    fork
      begin
        bulk_beat(64'hB0, 1, 0);
        bulk_beat(64'hB1, 0, 1);
        bulk_beat(64'hC0, 1, 0);
        bulk_beat(64'hC1, 0, 1);
      end
      begin
        idle(2);
        sw_beat(32'h5, 32'h6, 32'h3);
        idle(2);
        out_ready = 1'b1;
      end
    join
    idle(8);
    chk(m_n == b + 5, "R5 count", 64'(m_n - b), 5);
    chk_beat(b,     "R6 bulk hold", 64'hB0, 1, 0, 0);
    chk_beat(b + 1, "R6 bulk hold", 64'hB1, 0, 1, 0);
    chk_beat(b + 2, "R5 sw first",  64'h6_0000_0005, 1, 1, 1);
    chk_beat(b + 3, "R5 bulk after", 64'hC0, 1, 0, 0);
    chk_beat(b + 4, "R5 bulk after", 64'hC1, 0, 1, 0);
  endtask

  task automatic t_full;
    int b = m_n;
    out_ready = 1'b0;
    for (int i = 0; i < 8; i++) sw_beat(32'(i), 32'(256 + i), 32'h3);
    wr(2'd0, 32'h8); wr(2'd1, 32'h108);
    fork
      wr(2'd2, 32'h3);
      begin
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(csr_waitreq, "R3 waitreq while full", 64'(csr_waitreq), 1);
        end
        @(posedge clk); #2;
        out_ready = 1'b1;
      end
    join
    idle(20);
    chk(m_n == b + 9, "R3 none lost", 64'(m_n - b), 9);
    for (int i = 0; i < 9; i++)
      chk_beat(b + i, "R3 order", {32'(256 + i), 32'(i)}, 1, 1, 1);
  endtask

  task automatic t_nonposted;
    int b = m_n;
    // tag 5 below range: three-beat packet dropped entirely
    sw_beat(32'h1, 32'h2, 32'h0000_0505);
    sw_beat(32'h3, 32'h4, 32'h0);
    sw_beat(32'h5, 32'h6, 32'h2);
    // tag 40 above range, single beat
    sw_beat(32'h7, 32'h8, 32'h0000_2807);
    idle(8);
    chk(m_n == b, "R7 bad tag dropped", 64'(m_n - b), 0);
    chk(!np_pending, "R7 no pending", 64'(np_pending), 0);
    sw_beat(32'hAA, 32'hBB, 32'h0000_1407);
    idle(6);
    chk(np_pending, "R8 pending set", 64'(np_pending), 1);
    chk_beat(b, "R8 accepted", 64'hBB_0000_00AA, 1, 1, 1);
    sw_beat(32'hCC, 32'hDD, 32'h0000_1107);
    sw_beat(32'hEE, 32'hFF, 32'h3);
    idle(8);
    chk(m_n == b + 2, "R8 second refused", 64'(m_n - b), 2);
    chk_beat(b + 1, "R8 posted passes", 64'hFF_0000_00EE, 1, 1, 1);
    cpl_in = 1'b1; idle(1); cpl_in = 1'b0;
    @(negedge clk);
    chk(!np_pending, "R8 cleared by completion", 64'(np_pending), 0);
    @(posedge clk); #2;
    sw_beat(32'h77, 32'h88, 32'h0000_1F07);
    idle(8);
    chk_beat(b + 2, "R8 accepted after completion", 64'h88_0000_0077, 1, 1, 1);
    chk(np_pending, "R8 pending again", 64'(np_pending), 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #2 rst = 1'b0;
    t_reset;
    t_single;
    t_multi;
    t_priority;
    t_full;
    t_nonposted;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule